// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This block is a system watchdog with one 16-bit control word. The control word is protected by a key. A new configuration is taken only from the write that comes straight after a two-word unlock key. A different two-word key restarts the count. The timeout is a power of two of a base clock. A one-hot field in the control word selects an exponent from 25 to 30, which gives nominal periods of 1 to 32 seconds at about 33 MHz. When the count runs out and both enable bits are set, the block raises a one-cycle system reset request. It also sets a cause flag that survives the ordinary reset and is cleared only by power-on reset or by software.

Software arms the watchdog as follows. It drops the echo-mode input, writes the unlock pair and then the new control value, and restores echo mode. After that it refreshes the count with the refresh pair before the period ends. While echo mode is high, every control write is discarded. The `EXP_SHIFT` parameter lowers every exponent by a fixed amount so that a short simulation can reach expiry.

Top module: `guard_timer`

## Requirements
- R1: After `rst_n` and `por_n` are low, `ctrl_rd` reads 0x0020 (counting off, reset generation off, exponent 30), and `rst_req` and `wdt_expired` are 0. `wdt_cause` is cleared only by `por_n` and keeps its value through `rst_n`.
- R2: A control write (`wr_sel`=0) loads the control word only when it directly follows a write of 0x3333 and then a write of 0xCCCC to the control address. Any other control write leaves `ctrl_rd` unchanged.
- R3: An unlock opens a window for exactly one write. The second write after an unlock is not loaded.
- R4: A control write of any other value between 0x3333 and 0xCCCC cancels the unlock, so the write after 0xCCCC is not loaded.
- R5: A control write of 0xAAAA followed directly by 0x5555 restarts the count from zero. If another control write comes between the two words, the count is not restarted.
- R6: Bits [5:0] of the control word form a one-hot exponent field: bit i selects exponent E = 25+i. Expiry comes 2^(E−EXP_SHIFT) clock cycles after the refresh edge. A loaded value whose field is not one-hot keeps the previous exponent field.
- R7: Bit 15 enables counting and bit 14 enables reset generation. `rst_req` is a pulse of exactly one cycle, and it is raised on expiry only when both bits are set.
- R8: After expiry the counter holds at zero and `wdt_expired` stays at 1. No further `rst_req` comes until a refresh or until counting is disabled.
- R9: An expiry that raises `rst_req` also sets `wdt_cause`. A status write (`wr_sel`=1) with bit 0 set clears it, and a status write with bit 0 clear leaves it set.
- R10: While `echo_mode` is 1, control writes are ignored completely, including key words. Status writes still take effect.
- R11: With bit 15 clear, the counter and `wdt_expired` clear. An expiry with bit 14 clear sets `wdt_expired` but gives no `rst_req` and does not set `wdt_cause`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| por_n | input | 1 | Power-on reset, active low; the only reset that clears the cause flag |
| rst_n | input | 1 | System reset, active low, for all other state |
| echo_mode | input | 1 | Bus echo mode; blocks control writes while high |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 1 | Address: 0 selects the control word, 1 selects the status word |
| wr_data | input | 16 | Write data |
| ctrl_rd | output | 16 | Current control word |
| wdt_cause | output | 1 | Sticky flag: last reset came from watchdog expiry |
| wdt_expired | output | 1 | Timer has expired and is holding |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bound checker checks, on every cycle, the properties that relate neighbouring cycles:
- the reset request lasts one cycle;
- a reset request needs both enable bits in the previous cycle;
- a request coincides with the expired state and the cause flag;
- the cause flag falls only on a status write with bit 0 set;
- an echo-blocked write leaves the control word stable;
- disabling clears the expired state;
- the exponent field stays one-hot.

Only the bench scenarios can show the properties that depend on a history of writes. These are the exact timeout length for each exponent, the acceptance or rejection of a load after a complete, cancelled or spent key sequence, and a refresh restarting the count or, when cancelled, not restarting it. They also include the cause flag surviving `rst_n` and clearing only on `por_n`.

// File: rtl/gt_pkg.sv
package gt_pkg;
    localparam int CTRL_W   = 16;
    localparam int NUM_EXP  = 6;
    localparam int EXP_BASE = 25;
    localparam int RUN_BIT  = 15;
    localparam int RST_BIT  = 14;
    localparam int PAD_W    = CTRL_W - 2 - NUM_EXP;

    localparam logic [CTRL_W-1:0] KEY_UNLOCK_A  = 16'h3333;
    localparam logic [CTRL_W-1:0] KEY_UNLOCK_B  = 16'hCCCC;
    localparam logic [CTRL_W-1:0] KEY_REFRESH_A = 16'hAAAA;
    localparam logic [CTRL_W-1:0] KEY_REFRESH_B = 16'h5555;

    localparam logic [NUM_EXP-1:0] EXP_RESET = NUM_EXP'(1) << (NUM_EXP - 1);

    typedef struct packed {
        logic               run;
        logic               rst_en;
        logic [NUM_EXP-1:0] exp_sel;
        logic               open;
        logic               req;
    } ctl_state_t;

    function automatic logic is_onehot(input logic [NUM_EXP-1:0] v);
        return (v != '0) && ((v & (v - NUM_EXP'(1))) == '0);
    endfunction
endpackage

// File: rtl/gt_keypair.sv
// Detects a two-word key: FIRST on one accepted write, SECOND on the next.
module gt_keypair #(
    parameter int                DW     = 16,
    parameter logic [DW-1:0]     FIRST  = '0,
    parameter logic [DW-1:0]     SECOND = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          flush,
    input  logic [DW-1:0] data,
    output logic          hit
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        hit     = 1'b0;
        if (flush) begin
            armed_d = 1'b0;
        end else if (wr) begin
            hit     = armed_q && (data == SECOND);
            armed_d = (data == FIRST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end
endmodule

// File: rtl/gt_count.sv
// Power-of-two timeout counter with hold-after-expiry.
module gt_count #(
    parameter int EXP_BASE  = 25,
    parameter int NUM_EXP   = 6,
    parameter int EXP_SHIFT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [NUM_EXP-1:0] exp_sel,
    output logic               fire,
    output logic               expired
);
    localparam int CW = EXP_BASE + NUM_EXP - 1 - EXP_SHIFT;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          expired;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic [NUM_EXP-1:0] term;
    logic at_end;

    for (genvar i = 0; i < NUM_EXP; i++) begin : g_term
        localparam int W = EXP_BASE + i - EXP_SHIFT;
        assign term[i] = &s_q.cnt[W-1:0];
    end

    assign at_end = |(term & exp_sel);

    always_comb begin
        s_d  = s_q;
        fire = 1'b0;
        if (!run || restart) begin
            s_d.cnt     = '0;
            s_d.expired = 1'b0;
        end else if (s_q.expired) begin
            s_d.cnt = '0;
        end else if (at_end) begin
            fire        = 1'b1;
            s_d.cnt     = '0;
            s_d.expired = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign expired = s_q.expired;
endmodule

// File: rtl/gt_cause.sv
// Sticky reset-cause flag, cleared only by power-on reset or a write-one.
module gt_cause (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set)      flag_d = 1'b1;
        else if (clr) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import gt_pkg::*;
#(
    parameter int EXP_SHIFT = 0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              echo_mode,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic              wdt_cause,
    output logic              wdt_expired,
    output logic              rst_req
);
    ctl_state_t s_d, s_q;

    logic wr_ctrl, seq_wr, seq_flush;
    logic unlock_hit, refresh_hit;
    logic fire, rst_fire;
    logic cause_clr;

    assign wr_ctrl   = wr_en && !wr_sel && !echo_mode;
    assign seq_wr    = wr_ctrl && !s_q.open;
    assign seq_flush = wr_ctrl && s_q.open;
    assign cause_clr = wr_en && wr_sel && wr_data[0];

    gt_keypair #(
        .DW(CTRL_W), .FIRST(KEY_UNLOCK_A), .SECOND(KEY_UNLOCK_B)
    ) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr(seq_wr), .flush(seq_flush),
        .data(wr_data), .hit(unlock_hit)
    );

    gt_keypair #(
        .DW(CTRL_W), .FIRST(KEY_REFRESH_A), .SECOND(KEY_REFRESH_B)
    ) u_refresh (
        .clk(clk), .rst_n(rst_n), .wr(seq_wr), .flush(seq_flush),
        .data(wr_data), .hit(refresh_hit)
    );

    gt_count #(
        .EXP_BASE(EXP_BASE), .NUM_EXP(NUM_EXP), .EXP_SHIFT(EXP_SHIFT)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .run(s_q.run), .restart(refresh_hit),
        .exp_sel(s_q.exp_sel), .fire(fire), .expired(wdt_expired)
    );

    assign rst_fire = fire && s_q.rst_en;

    gt_cause u_cause (
        .clk(clk), .por_n(por_n), .set(rst_fire), .clr(cause_clr),
        .flag(wdt_cause)
    );

    always_comb begin
        s_d     = s_q;
        s_d.req = rst_fire;
        if (unlock_hit) begin
            s_d.open = 1'b1;
        end
        if (seq_flush) begin
            s_d.open   = 1'b0;
            s_d.run    = wr_data[RUN_BIT];
            s_d.rst_en = wr_data[RST_BIT];
            if (is_onehot(wr_data[NUM_EXP-1:0])) begin
                s_d.exp_sel = wr_data[NUM_EXP-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.exp_sel <= EXP_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_rd = {s_q.run, s_q.rst_en, {PAD_W{1'b0}}, s_q.exp_sel};
    assign rst_req = s_q.req;
endmodule

// File: rtl/gt_chk.sv
module gt_chk (
    input logic        clk,
    input logic        por_n,
    input logic        rst_n,
    input logic        echo_mode,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [15:0] wr_data,
    input logic [15:0] ctrl_rd,
    input logic        wdt_cause,
    input logic        wdt_expired,
    input logic        rst_req
);
    // R7
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |=> !rst_req);

    // R7
    req_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |-> $past(ctrl_rd[15] && ctrl_rd[14]));

    // R8
    req_holds_expired_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |-> wdt_expired);

    // R9
    req_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |-> wdt_cause);

    // R9
    cause_clear_by_write_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(wdt_cause) |-> $past(wr_en && wr_sel && wr_data[0]));

    // R10
    echo_blocks_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (echo_mode && wr_en && !wr_sel) |=> $stable(ctrl_rd));

    // R11
    disable_clears_expired_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !ctrl_rd[15] |=> !wdt_expired);

    // R6
    exp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $countones(ctrl_rd[5:0]) == 1);
endmodule

bind guard_timer gt_chk u_chk (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .echo_mode(echo_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
    .wdt_cause(wdt_cause), .wdt_expired(wdt_expired), .rst_req(rst_req)
);

// File: tb/guard_timer_bench.sv
module guard_timer_bench;
    localparam int SHIFT = 22;
    localparam int MAX_CYC = 200000;

    localparam logic [15:0] VEC_CTRL [0:5] = '{16'hC001, 16'hC002, 16'hC004,
                                               16'hC008, 16'hC010, 16'hC020};
    localparam int VEC_CYC [0:5] = '{8, 16, 32, 64, 128, 256};

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        echo_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] ctrl_rd;
    logic        wdt_cause, wdt_expired, rst_req;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    guard_timer #(.EXP_SHIFT(SHIFT)) u_guard_timer (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .echo_mode(echo_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
        .wdt_cause(wdt_cause), .wdt_expired(wdt_expired), .rst_req(rst_req)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge; one write = one rising edge.
    task automatic wr(input logic sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic unlock_load(input logic [15:0] v);
        wr(1'b0, 16'h3333); wr(1'b0, 16'hCCCC); wr(1'b0, v);
    endtask

    task automatic refresh();
        wr(1'b0, 16'hAAAA); wr(1'b0, 16'h5555);
    endtask

    task automatic measure(output int n);
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            n++;
            if (rst_req) break;
        end
    endtask

    task automatic count_pulses(input int cyc, output int p);
        p = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (rst_req) p++;
        end
    endtask

    initial begin
        int n, p;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ctrl", ctrl_rd, 16'h0020);
        check("R1 req", rst_req, 0);
        check("R1 expired", wdt_expired, 0);
        check("R1 cause", wdt_cause, 0);

        // Vector table: every exponent
        for (int i = 0; i < 6; i++) begin
            unlock_load(VEC_CTRL[i]);
            check("R2 load", ctrl_rd, VEC_CTRL[i]);
            refresh();
            measure(n);
            check("R6 period", n, VEC_CYC[i]);
            check("R9 cause set", wdt_cause, 1);
            @(negedge clk);
            check("R7 pulse width", rst_req, 0);
            check("R8 expired", wdt_expired, 1);
            wr(1'b1, 16'h0001);
            check("R9 cause clear", wdt_cause, 0);
        end

        // R8 hold after expiry
        count_pulses(300, p);
        check("R8 no repeat", p, 0);
        check("R8 still expired", wdt_expired, 1);
        refresh();
        check("R8 refresh clears", wdt_expired, 0);

        unlock_load(16'hC001);
        check("R2 short", ctrl_rd, 16'hC001);
        // R3 window spent
        wr(1'b0, 16'h4001);
        check("R3 one write", ctrl_rd, 16'hC001);
        // R2 no unlock
        wr(1'b0, 16'h0002);
        check("R2 locked", ctrl_rd, 16'hC001);
        // R4 aborted unlock
        wr(1'b0, 16'h3333); wr(1'b0, 16'h1234); wr(1'b0, 16'hCCCC); wr(1'b0, 16'h4002);
        check("R4 abort", ctrl_rd, 16'hC001);

        // R5 refresh restarts count
        refresh();
        repeat (4) @(negedge clk);
        refresh();
        measure(n);
        check("R5 restart", n, 8);
        // R5 interrupted refresh
        refresh();
        wr(1'b0, 16'hAAAA); wr(1'b0, 16'h1111); wr(1'b0, 16'h5555);
        measure(n);
        check("R5 aborted", n, 5);

        // R10 echo blocks control writes, not status writes
        echo_mode = 1'b1;
        unlock_load(16'h0004);
        check("R10 ctrl blocked", ctrl_rd, 16'hC001);
        refresh();
        check("R10 refresh blocked", wdt_expired, 1);
        wr(1'b1, 16'h0001);
        check("R10 status ok", wdt_cause, 0);
        echo_mode = 1'b0;

        // R6 non-one-hot exponent keeps field
        unlock_load(16'hC003);
        check("R6 onehot keep", ctrl_rd, 16'hC001);

        // R9 write zero, survive rst_n, clear by por_n
        refresh();
        measure(n);
        check("R9 cause before", wdt_cause, 1);
        wr(1'b1, 16'h0000);
        check("R9 write zero", wdt_cause, 1);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check("R1 cause survives", wdt_cause, 1);
        check("R1 ctrl after rst", ctrl_rd, 16'h0020);
        check("R1 expired after rst", wdt_expired, 0);
        por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
        check("R1 por clears", wdt_cause, 0);

        // R11 expiry without reset enable, then disable
        unlock_load(16'h8001);
        refresh();
        count_pulses(12, p);
        check("R11 no pulse", p, 0);
        check("R11 expired", wdt_expired, 1);
        check("R11 no cause", wdt_cause, 0);
        unlock_load(16'h0001);
        @(negedge clk);
        check("R11 disable clears", wdt_expired, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule